// File: doc/BRIEF.md
# SD Command-Line Host Engine

This block drives the command line of an SD card. It sends one command frame and collects the card's reply. Software programs a command word and then an argument through a plain 32-bit register bus. Writing the argument starts the transaction. The engine serialises a 48-bit frame on a divided SD clock. It then listens for a reply of 48 or 136 bits, or for no reply at all, depending on the command word.

When the reply arrives, the engine checks its CRC7 and, if asked, the echoed command index. It keeps one 32-bit slice of the reply, picked by the command word. It then raises either a completion bit or an error bit, along with a cause. If no reply comes within the programmed number of SD clock cycles, the engine reports a timeout. A software-reset register holds the whole engine idle, and the clock divider can be changed while it is held.

Top module: `sd_cmd_host`

## Requirements
- R1: After reset, the normal status (0x30), error status (0x34) and card status (0x08) read 0, the command line is not driven, and `sd_cmd_o` is 1.
- R2: An argument write sends 48 bits on `sd_cmd_o`, MSB first, in this order: 0, 1, command index (command word bits 13:8), the 32-bit argument, the CRC7 (x^7+x^3+1, initial value 0) of those first 40 bits, and then 1.
- R3: The SD clock period is 2×(divider+1) system clocks, where the divider is at offset 0x4C.
- R4: `sd_cmd_o` changes only on a falling SD clock edge.
- R5: A write to the command register (0x04) alone starts nothing. Only a write to the argument register (0x00) launches a command.
- R6: Card status bit 0 reads 1 while a command is in progress.
- R7: For a 48-bit reply (response type field, bits 1:0, equal to 10), the response register (0x0C) holds reply bits 39:8. A good reply sets normal status bit 0 and leaves bit 15 clear. Replies are sampled on the rising SD clock edge, and the start is the first 0 seen after the frame.
- R8: For a 136-bit reply (type 01), the response register holds reply bits [127-32w -: 32], where w is command word bits 7:6. No index check is applied to these replies.
- R9: When the CRC check is enabled (command bit 3) and the received CRC7 differs from the CRC7 of the covered bits (47:8 for short replies, 127:8 for long ones), error status bit 1 and normal status bit 15 are set. When the check is disabled, a bad CRC is not reported.
- R10: When the index check is enabled (command bit 4) and a 48-bit reply echoes an index (bits 45:40) different from the one sent, error status bit 3 and normal status bit 15 are set. When the check is disabled, the mismatch is ignored.
- R11: If no start bit is seen within the timeout (offset 0x2C) plus one rising SD clock edges after the frame, error status bit 0 and normal status bit 15 are set.
- R12: With response type 00, normal status bit 0 is set two SD clock cycles after the frame, with no timeout and no error.
- R13: Any write to 0x30 or 0x34 clears that register. A status bit that the engine sets in the same cycle as a clear survives that cycle.
- R14: While software reset (offset 0x28, bit 0) is 1, the engine stays idle, the status registers stay 0, and an argument write launches nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sd_clk | output | 1 | Divided SD clock |
| sd_cmd_o | output | 1 | Command line output value |
| sd_cmd_oe | output | 1 | Command line output enable |
| sd_cmd_i | input | 1 | Command line input (pulled high when idle) |

## Verification
The engine's completion update and a software clear of the normal status register can land in the same system cycle. The bench provokes this by launching a command with no reply and then writing 0 to the status register on every cycle while it reads the register back. The rule that a set survives that cycle is judged by the completion bit being visible for exactly one cycle, not zero. CRC and index faults can also be injected together into the same reply; both causes must then appear in the error register at once.

// File: rtl/sdh_pkg.sv
// Shared constants, state type and CRC7 helpers for the SD command engine.
// Assumes MSB-first serialisation and the CRC7 polynomial x^7+x^3+1.
package sdh_pkg;
    localparam int FRAME_BITS = 48;
    localparam logic [1:0] RT_NONE = 2'b00;
    localparam logic [1:0] RT_LONG = 2'b01;

    typedef enum logic [2:0] {ST_IDLE, ST_TX, ST_GAP, ST_WAIT, ST_RX} sdh_state_t;

    // Advance a CRC7 register by one input bit.
    function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

    // CRC7 over the 40 leading bits of a command frame.
    function automatic logic [6:0] crc7_of40(input logic [39:0] d);
        logic [6:0] c;
        c = '0;
        for (int i = 39; i >= 0; i--) c = crc7_step(c, d[i]);
        return c;
    endfunction
endpackage

// File: rtl/sdh_clkgen.sv
// SD clock divider: produces sd_clk with period 2*(div+1) system clocks and
// one-cycle strobes marking the system edge on which sd_clk rises or falls.
// Assumes hold parks the clock low and restarts the count from zero.
module sdh_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [DIV_W-1:0] div,
    output logic             sd_clk,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] cnt_q;
    logic             tick;

    assign tick     = !hold && (cnt_q >= div);
    assign rise_stb = tick && !sd_clk;
    assign fall_stb = tick && sd_clk;

    // Count system clocks and toggle the SD clock at each terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt_q  <= '0;
            sd_clk <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            sd_clk <= !sd_clk;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sdh_cmd_fsm.sv
// Command sequencer: serialises the 48-bit frame on falling SD edges, then
// waits for, receives and checks the reply on rising SD edges. done pulses
// for one cycle with err = {index, crc, timeout}. Assumes the card releases
// the line high and that start arrives only while idle.
module sdh_cmd_fsm import sdh_pkg::*; #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             start,
    input  logic [5:0]       cmd_idx,
    input  logic [1:0]       rtype,
    input  logic [1:0]       wsel,
    input  logic             crc_en,
    input  logic             idx_en,
    input  logic [31:0]      arg,
    input  logic [TMO_W-1:0] tmo,
    input  logic             rise_stb,
    input  logic             fall_stb,
    input  logic             cmd_in,
    output logic             cmd_out,
    output logic             cmd_oe,
    output logic             busy,
    output logic             done,
    output logic [2:0]       err,
    output logic [31:0]      resp
);
    sdh_state_t       st;
    logic [FRAME_BITS-1:0] sh_tx;
    logic [7:0]       bitcnt, pos, lo, crc_hi;
    logic [TMO_W-1:0] tmo_cnt;
    logic [31:0]      rx_sh;
    logic [6:0]       crc_q, crc_rx;
    logic [5:0]       idx_q, idx_rx;
    logic [1:0]       wsel_q;
    logic             none_q, long_q, crc_en_q, idx_en_q;

    assign busy = (st != ST_IDLE) || done;

    // Position of the incoming bit, slice start and last CRC-covered bit.
    always_comb begin
        pos    = (long_q ? 8'd135 : 8'd47) - bitcnt;
        lo     = long_q ? (8'd96 - {1'b0, wsel_q, 5'd0}) : 8'd8;
        crc_hi = long_q ? 8'd127 : 8'd46;
    end

    // Main sequence: transmit, gap/wait, receive, report.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            st <= ST_IDLE; cmd_out <= 1'b1; cmd_oe <= 1'b0; done <= 1'b0;
            err <= '0; bitcnt <= '0; tmo_cnt <= '0; resp <= '0; sh_tx <= '0;
            rx_sh <= '0; crc_q <= '0; crc_rx <= '0; idx_q <= '0; idx_rx <= '0;
            wsel_q <= '0; none_q <= 1'b0; long_q <= 1'b0;
            crc_en_q <= 1'b0; idx_en_q <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    st       <= ST_TX;
                    bitcnt   <= '0;
                    sh_tx    <= {2'b01, cmd_idx, arg, crc7_of40({2'b01, cmd_idx, arg}), 1'b1};
                    idx_q    <= cmd_idx;
                    wsel_q   <= wsel;
                    none_q   <= (rtype == RT_NONE);
                    long_q   <= (rtype == RT_LONG);
                    crc_en_q <= crc_en;
                    idx_en_q <= idx_en;
                end
                ST_TX: if (fall_stb) begin
                    if (bitcnt == 8'(FRAME_BITS)) begin
                        cmd_oe  <= 1'b0;
                        cmd_out <= 1'b1;
                        bitcnt  <= '0;
                        tmo_cnt <= '0;
                        st      <= none_q ? ST_GAP : ST_WAIT;
                    end else begin
                        cmd_oe  <= 1'b1;
                        cmd_out <= sh_tx[FRAME_BITS-1];
                        sh_tx   <= {sh_tx[FRAME_BITS-2:0], 1'b0};
                        bitcnt  <= bitcnt + 1'b1;
                    end
                end
                ST_GAP: if (rise_stb) begin
                    if (bitcnt == 8'd1) begin
                        st <= ST_IDLE; done <= 1'b1; err <= 3'b000;
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_WAIT: if (rise_stb) begin
                    if (!cmd_in) begin
                        st     <= ST_RX;
                        bitcnt <= 8'd1;
                        crc_q  <= long_q ? 7'd0 : crc7_step(7'd0, 1'b0);
                    end else if (tmo_cnt == tmo) begin
                        st <= ST_IDLE; done <= 1'b1; err <= 3'b001;
                    end else begin
                        tmo_cnt <= tmo_cnt + 1'b1;
                    end
                end
                ST_RX: if (rise_stb) begin
                    rx_sh  <= {rx_sh[30:0], cmd_in};
                    bitcnt <= bitcnt + 1'b1;
                    if (pos >= 8'd8 && pos <= crc_hi) crc_q <= crc7_step(crc_q, cmd_in);
                    if (pos == lo)     resp   <= {rx_sh[30:0], cmd_in};
                    if (pos == 8'd40)  idx_rx <= {rx_sh[4:0], cmd_in};
                    if (pos == 8'd1)   crc_rx <= {rx_sh[5:0], cmd_in};
                    if (pos == 8'd0) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                        err  <= {idx_en_q && !long_q && (idx_rx != idx_q),
                                 crc_en_q && (crc_rx != crc_q), 1'b0};
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R4: the line moves only on the system edge where the SD clock falls.
    assert_cmd_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_out) |-> ($past(fall_stb) || $past(hold)));

    // R6: the line is never driven unless a command is in progress.
    assert_drive_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> busy);
endmodule

// File: rtl/sd_cmd_host.sv
// SD command-line host: register file, status logic and the bus-side launch.
// Register offsets: 0x00 argument (write launches), 0x04 command word,
// 0x08 card status, 0x0C response, 0x28 software reset, 0x2C timeout,
// 0x30 normal status, 0x34 error status, 0x4C clock divider.
// Assumes single-cycle writes and a combinational read port.
module sd_cmd_host #(
    parameter int DIV_W = 8,
    parameter int TMO_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sd_clk,
    output logic        sd_cmd_o,
    output logic        sd_cmd_oe,
    input  logic        sd_cmd_i
);
    localparam logic [7:0] A_ARG = 8'h00, A_CMD = 8'h04, A_CST = 8'h08,
                           A_RSP = 8'h0C, A_SRS = 8'h28, A_TMO = 8'h2C,
                           A_NST = 8'h30, A_EST = 8'h34, A_DIV = 8'h4C;

    logic [31:0]      arg_q, resp;
    logic [13:0]      cmd_q;
    logic [TMO_W-1:0] tmo_q;
    logic [DIV_W-1:0] div_q;
    logic             srst_q, busy, done, start, rise_stb, fall_stb;
    logic [2:0]       err;
    logic [15:0]      nstat_q, nstat_d;
    logic [3:0]       estat_q, estat_d;

    assign start = bus_wr && (bus_addr == A_ARG) && !srst_q && !busy;

    // Software-visible configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_q <= '0; cmd_q <= '0; tmo_q <= '1; div_q <= '0; srst_q <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_ARG: arg_q  <= bus_wdata;
                A_CMD: cmd_q  <= bus_wdata[13:0];
                A_TMO: tmo_q  <= bus_wdata[TMO_W-1:0];
                A_DIV: div_q  <= bus_wdata[DIV_W-1:0];
                A_SRS: srst_q <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    // Status next state: a clear write first, then engine sets on top.
    always_comb begin
        nstat_d = (bus_wr && bus_addr == A_NST) ? '0 : nstat_q;
        estat_d = (bus_wr && bus_addr == A_EST) ? '0 : estat_q;
        if (done) begin
            if (|err) nstat_d[15] = 1'b1;
            else      nstat_d[0]  = 1'b1;
            estat_d = estat_d | {err[2], 1'b0, err[1], err[0]};
        end
    end

    // Status registers, cleared by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_q) begin
            nstat_q <= '0; estat_q <= '0;
        end else begin
            nstat_q <= nstat_d; estat_q <= estat_d;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            A_ARG:   bus_rdata = arg_q;
            A_CMD:   bus_rdata = {18'd0, cmd_q};
            A_CST:   bus_rdata = {31'd0, busy};
            A_RSP:   bus_rdata = resp;
            A_SRS:   bus_rdata = {31'd0, srst_q};
            A_TMO:   bus_rdata = 32'(tmo_q);
            A_NST:   bus_rdata = {16'd0, nstat_q};
            A_EST:   bus_rdata = {28'd0, estat_q};
            A_DIV:   bus_rdata = 32'(div_q);
            default: bus_rdata = '0;
        endcase
    end

    sdh_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .hold(srst_q), .div(div_q),
        .sd_clk(sd_clk), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    sdh_cmd_fsm #(.TMO_W(TMO_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hold(srst_q), .start(start),
        .cmd_idx(cmd_q[13:8]), .rtype(cmd_q[1:0]), .wsel(cmd_q[7:6]),
        .crc_en(cmd_q[3]), .idx_en(cmd_q[4]), .arg(bus_wdata), .tmo(tmo_q),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .cmd_in(sd_cmd_i),
        .cmd_out(sd_cmd_o), .cmd_oe(sd_cmd_oe), .busy(busy), .done(done),
        .err(err), .resp(resp)
    );

    // R7: completion appears only at the end of an active command.
    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nstat_q[0]) |-> $past(busy));

    // R14: a held software reset keeps the engine idle.
    assert_hold_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> !busy);
endmodule

// File: tb/sim_sd_cmd_host.sv
// Self-checking bench: a card model answers frames; expectations come from
// bench-side CRC and field arithmetic. Random commands plus directed corners.
module sim_sd_cmd_host;
    logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, sd_cmd_i = 1'b1;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic sd_clk, sd_cmd_o, sd_cmd_oe;
    int n_tests = 0, n_fail = 0, wd = 0, r4_bad = 0;
    logic prev_sd = 1'b0, prev_cmd = 1'b1;

    always #2 clk = !clk;

    sd_cmd_host u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sd_clk(sd_clk),
        .sd_cmd_o(sd_cmd_o), .sd_cmd_oe(sd_cmd_oe), .sd_cmd_i(sd_cmd_i));

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 190000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired act=%0d exp=<190000", wd);
            $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    // R4 monitor: any CMD change must coincide with an SD clock fall.
    always @(negedge clk) begin
        if (rst_n && sd_cmd_o !== prev_cmd && !(prev_sd && !sd_clk)) r4_bad = r4_bad + 1;
        prev_sd = sd_clk; prev_cmd = sd_cmd_o;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests = n_tests + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc(input logic [135:0] v, input int n);
        logic [6:0] c;
        logic f;
        c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            f = v[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (f) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [31:0] cmdw(input logic [5:0] idx, input logic [1:0] w,
                                          input bit ie, input bit ce, input logic [1:0] rt);
        return {18'd0, idx, w, 1'b0, ie, ce, 1'b0, rt};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic clr();
        wr(8'h30, 0); wr(8'h34, 0);
    endtask

    task automatic set_div(input logic [31:0] d);
        wr(8'h28, 1); wr(8'h4C, d); wr(8'h28, 0);
    endtask

    // Launch a command and capture the 48 transmitted bits.
    task automatic send(input logic [31:0] cw, input logic [31:0] arg, output logic [47:0] fr);
        logic [31:0] v;
        wr(8'h04, cw); wr(8'h00, arg);
        rd(8'h08, v);
        chk(v[0] == 1'b1, "R6 busy during command", v, 1);
        do @(posedge sd_clk); while (!sd_cmd_oe);
        fr[47] = sd_cmd_o;
        for (int i = 46; i >= 0; i--) begin @(posedge sd_clk); fr[i] = sd_cmd_o; end
    endtask

    task automatic respond(input logic [135:0] bits, input int len, input int gap);
        repeat (gap) @(negedge sd_clk);
        for (int i = len - 1; i >= 0; i--) begin @(negedge sd_clk); #1 sd_cmd_i = bits[i]; end
        @(negedge sd_clk); #1 sd_cmd_i = 1'b1;
    endtask

    task automatic wait_stat(output logic [31:0] ns);
        ns = 0;
        for (int k = 0; k < 20000 && ns == 0; k++) rd(8'h30, ns);
    endtask

    function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg);
        return {2'b01, idx, arg, ref_crc({96'd0, 2'b01, idx, arg}, 40), 1'b1};
    endfunction

    // One 48-bit-reply command with optional CRC / index faults.
    task automatic short_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [31:0] pay,
                             input bit ce, input bit ie, input bit bad_crc, input bit bad_idx);
        logic [47:0] fr;
        logic [39:0] head;
        logic [6:0] c;
        logic [31:0] ns, es, rs;
        bit ec, ei;
        clr();
        send(cmdw(idx, 2'd0, ie, ce, 2'b10), arg, fr);
        chk(fr == exp_frame(idx, arg), "R2 frame", fr, exp_frame(idx, arg));
        head = {2'b00, bad_idx ? ~idx : idx, pay};
        c = ref_crc({96'd0, head}, 40) ^ (bad_crc ? 7'h01 : 7'h00);
        respond({88'd0, head, c, 1'b1}, 48, 2 + int'($urandom_range(0, 3)));
        wait_stat(ns); rd(8'h34, es); rd(8'h0C, rs);
        ec = ce && bad_crc; ei = ie && bad_idx;
        if (ec || ei) begin
            chk(ns == 32'h8000, ec ? "R9 error flag" : "R10 error flag", ns, 32'h8000);
            chk(es == {28'd0, ei, 1'b0, ec, 1'b0}, ec ? "R9 crc cause" : "R10 index cause",
                es, {28'd0, ei, 1'b0, ec, 1'b0});
        end else begin
            chk(ns == 32'h1, (bad_crc || bad_idx) ? "R9/R10 fault ignored when disabled" : "R7 complete", ns, 1);
            chk(rs == pay, "R7 response bits 39:8", rs, pay);
        end
    endtask

    initial begin
        logic [31:0] v, ns, es;
        logic [47:0] fr;
        logic [119:0] body;
        logic [135:0] lr;
        realtime t0, t1;
        int ones;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'h30, v); chk(v == 0, "R1 normal status", v, 0);
        rd(8'h34, v); chk(v == 0, "R1 error status", v, 0);
        rd(8'h08, v); chk(v == 0, "R1 card status", v, 0);
        chk(sd_cmd_oe == 0 && sd_cmd_o == 1, "R1 line idle", {sd_cmd_oe, sd_cmd_o}, 2'b01);

        // R3: clock period for two divider settings.
        for (int d = 0; d < 3; d += 2) begin
            set_div(d);
            @(posedge sd_clk); t0 = $realtime; @(posedge sd_clk); t1 = $realtime;
            chk(int'((t1 - t0) / 4.0) == 2 * (d + 1), "R3 SD clock period",
                int'((t1 - t0) / 4.0), 2 * (d + 1));
        end
        set_div(1);

        // R5: a command write alone launches nothing.
        wr(8'h04, cmdw(6'd17, 0, 0, 0, 2'b10));
        repeat (60) @(negedge clk);
        rd(8'h08, v); chk(v == 0 && sd_cmd_oe == 0, "R5 command write idle", v, 0);

        // R14: argument write during software reset is ignored.
        wr(8'h28, 1); wr(8'h00, 32'h1234);
        repeat (60) @(negedge clk);
        rd(8'h08, v); chk(v == 0, "R14 held idle", v, 0);
        rd(8'h30, v); chk(v == 0, "R14 status stays 0", v, 0);
        wr(8'h28, 0);
        repeat (40) @(negedge clk);
        rd(8'h08, v); chk(v == 0 && sd_cmd_oe == 0, "R14 no launch after release", v, 0);

        // Directed corners, then random 48-bit commands.
        short_cmd(6'd8, 32'h1AA, 32'h0000_01AA, 1, 1, 0, 0);
        short_cmd(6'd63, 32'hFFFF_FFFF, 32'h0, 1, 1, 1, 1);
        short_cmd(6'd0, 32'h0, 32'hFFFF_FFFF, 0, 0, 1, 1);
        for (int k = 0; k < 10; k++)
            short_cmd(6'($urandom), $urandom, $urandom, 1'($urandom), 1'($urandom),
                      ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));

        // R8: 136-bit replies, each word slice, index check skipped.
        for (int w = 0; w < 4; w++) begin
            clr();
            body = {$urandom, $urandom, $urandom, 24'($urandom)};
            lr = {8'h3F, body, ref_crc({16'd0, body}, 120), 1'b1};
            send(cmdw(6'd9, 2'(w), 1, 1, 2'b01), $urandom, fr);
            respond(lr, 136, 2);
            wait_stat(ns); rd(8'h0C, v);
            chk(ns == 1, "R8 long reply complete", ns, 1);
            chk(v == lr[127 - 32 * w -: 32], "R8 word select", v, lr[127 - 32 * w -: 32]);
        end
        clr();
        body = {$urandom, $urandom, $urandom, 24'($urandom)};
        lr = {8'h3F, body, ref_crc({16'd0, body}, 120) ^ 7'h40, 1'b1};
        send(cmdw(6'd2, 0, 0, 1, 2'b01), 0, fr);
        respond(lr, 136, 3);
        wait_stat(ns); rd(8'h34, es);
        chk(ns == 32'h8000 && es == 32'h2, "R9 long reply crc error", es, 2);

        // R11: no reply within a short timeout.
        clr(); wr(8'h2C, 20);
        send(cmdw(6'd55, 0, 1, 1, 2'b10), 0, fr);
        wait_stat(ns); rd(8'h34, es);
        chk(ns == 32'h8000, "R11 timeout flag", ns, 32'h8000);
        chk(es == 32'h1, "R11 timeout cause", es, 1);

        // R12: no-reply command completes without timeout even at timeout 0.
        clr(); wr(8'h2C, 0);
        send(cmdw(6'd0, 0, 0, 0, 2'b00), 0, fr);
        chk(fr == exp_frame(6'd0, 0), "R2 frame idx 0", fr, exp_frame(6'd0, 0));
        wait_stat(ns); rd(8'h34, es);
        chk(ns == 1 && es == 0, "R12 no-reply complete", {es[15:0], ns[15:0]}, 1);

        // R13: clear on every cycle while completion lands; set must show once.
        clr();
        wr(8'h04, cmdw(6'd0, 0, 0, 0, 2'b00)); wr(8'h00, 0);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h30; bus_wdata = 0;
        ones = 0;
        for (int k = 0; k < 600; k++) begin @(negedge clk); #1 if (bus_rdata[0]) ones++; end
        bus_wr = 1'b0;
        chk(ones == 1, "R13 set wins over same-cycle clear", ones, 1);
        wr(8'h30, 0); rd(8'h30, v);
        chk(v == 0, "R13 clear by write", v, 0);

        chk(r4_bad == 0, "R4 CMD changes only on SD fall", r4_bad, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule